// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a small 32-bit load/store processor that spreads each instruction over several short clock steps. It handles register-register ALU operations, OR with an immediate, word load, word store and branch-if-equal. One memory port serves both instruction fetch and data access, and one ALU serves every step: PC increment, branch-target computation, address calculation and the operation itself.

Every control strobe is a plain input driven by an external step sequencer. The block returns the opcode and function fields of the held instruction and the ALU zero flag, so that the sequencer can choose the next step. Each value made in one step and used in a later one sits in a register: the operand registers, the ALU output register, the memory-data register and the branch-target register. No combinational path therefore takes longer than one clock to settle. The memory is ideal, meaning its read is combinational and its write is clocked.

Top module: `mcDatapath`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, the PC and all register-file entries are cleared. Afterwards, with `addrSel` low, `memAddr` reads 0.
- R2: At a clock edge with `irWr` high, the instruction register loads `memRData`. `opField` shows instruction bits 31:26 and `funcField` shows bits 5:0. A fetch step (`aluSrcA`=0, `aluSrcB`=00, add, `pcWr`=1, `pcSrc`=0) advances the PC by 4.
- R3: `memAddr` is the PC when `addrSel`=0 and the ALU output register when `addrSel`=1.
- R4: `aluOp` codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 signed less-than (result 1 or 0). Unused codes give 0. Operand A is the PC when `aluSrcA`=0 and operand register A when it is 1. `aluSrcB` picks 4 (00), operand register B (01), the extended immediate shifted left by two (10), or the extended immediate (11).
- R5: The 16-bit immediate (bits 15:0) is sign-extended when `extSigned`=1 and zero-extended when it is 0.
- R6: The PC is written when `pcWr`=1, or when `pcWrCond`=1 and `zero`=1. The new value is the ALU result if `pcSrc`=0 and the target register if it is 1. The target register loads the ALU result when `brWr`=1.
- R7: The register-file write address is rt (bits 20:16) when `dstSel`=0 and rd (bits 15:11) when it is 1. The write data is the ALU output register when `wbSel`=0 and the memory-data register when it is 1. The read ports use rs (bits 25:21) and rt.
- R8: Register 0 always reads 0, and writes to it have no effect.
- R9: `memWData` is operand register B, and `memWEn` follows `memWr`.
- R10: `zero` is high exactly when the current ALU result is 0.
- R11: While `irWr` is low, the instruction register and its fields do not change.
- R12: Operand registers A and B, the ALU output register and the memory-data register load on every clock. A value is therefore used one step after it is produced, never through a path that spans steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pcWr | input | 1 | Unconditional PC write |
| pcWrCond | input | 1 | PC write when zero is set |
| pcSrc | input | 1 | PC source: 0 ALU result, 1 target register |
| irWr | input | 1 | Instruction register load |
| brWr | input | 1 | Target register load |
| extSigned | input | 1 | 1 sign-extends, 0 zero-extends the immediate |
| aluSrcA | input | 1 | ALU operand A select |
| aluSrcB | input | 2 | ALU operand B select |
| aluOp | input | 3 | ALU operation code |
| addrSel | input | 1 | Memory address select: 0 PC, 1 ALU output register |
| memWr | input | 1 | Memory write request |
| regWr | input | 1 | Register-file write enable |
| dstSel | input | 1 | Write register select: 0 rt, 1 rd |
| wbSel | input | 1 | Write data select: 0 ALU output, 1 memory data |
| memRData | input | 32 | Memory read data |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Memory write data |
| memWEn | output | 1 | Memory write enable |
| opField | output | 6 | Opcode field of the held instruction |
| funcField | output | 6 | Function field of the held instruction |
| zero | output | 1 | ALU result is zero |

## Verification
Several properties are checked on every cycle:
- the PC holds unless an unconditional write or a qualified conditional write occurs;
- a taken branch loads the target register into the PC;
- a fetch step adds four to the PC;
- the instruction register holds while its load strobe is low;
- a subtract of equal operands raises `zero`;
- a read of register 0 returns 0.

Only the bench's instruction sequences can show the remaining behaviours. These are the arithmetic and logic results, the difference between sign and zero extension, the choice of write register and write data, and that a skipped branch path leaves its register untouched. The bench shows them by storing the register file to memory and comparing it with a behavioural reference.

// File: rtl/mcdpPkg.sv
package mcdpPkg;
  localparam int WORD_W    = 32;
  localparam int IMM_W     = 16;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5
  } aluOp_e;

  typedef enum logic [1:0] {
    SRCB_FOUR  = 2'b00,
    SRCB_REG   = 2'b01,
    SRCB_IMMSH = 2'b10,
    SRCB_IMM   = 2'b11
  } srcB_e;

  typedef struct packed {
    logic   pcWr;
    logic   pcWrCond;
    logic   pcSrc;
    logic   irWr;
    logic   brWr;
    logic   extSigned;
    logic   aluSrcA;
    srcB_e  aluSrcB;
    aluOp_e aluOp;
    logic   addrSel;
    logic   memWr;
    logic   regWr;
    logic   dstSel;
    logic   wbSel;
  } dpStrobes_t;
endpackage

// File: rtl/mcdpAlu.sv
module mcdpAlu
  import mcdpPkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_e       op,
  output logic [W-1:0] result,
  output logic         zero
);
  logic lessThan;
  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      ALU_SLT: result = {{(W-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/mcdpRegFile.sv
module mcdpRegFile #(
  parameter int W     = 32,
  parameter int COUNT = 32,
  localparam int AW   = $clog2(COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] rows [COUNT];

  for (genvar g = 0; g < COUNT; g++) begin : gRow
    if (g == 0) begin : gHardZero
      assign rows[g] = '0;
    end else begin : gStore
      always_ff @(posedge clk) begin
        if (rst) begin
          rows[g] <= '0;
        end else if (wrEn && (wrAddr == AW'(g))) begin
          rows[g] <= wrData;
        end
      end
    end
  end

  assign rdDataA = rows[rdAddrA];
  assign rdDataB = rows[rdAddrB];

  // R8: entry 0 reads back as zero on either port
  a_r8_port_a_zero: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA == '0));
  a_r8_port_b_zero: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == '0) |-> (rdDataB == '0));
endmodule

// File: rtl/mcdpCore.sv
module mcdpCore
  import mcdpPkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  dpStrobes_t   ctl,
  input  logic [W-1:0] memRData,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] memWData,
  output logic         memWEn,
  output logic [5:0]   opField,
  output logic [5:0]   funcField,
  output logic         zero
);
  localparam int EXT_PAD = W - IMM_W;

  logic [W-1:0] pcQ, irQ, targetQ, aQ, bQ, aluOutQ, mdrQ;
  logic [W-1:0] rdDataA, rdDataB;
  logic [W-1:0] immExt, immShifted, srcA, srcB, aluRes;
  logic [W-1:0] pcNext, wrData;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrAddr;
  logic [IMM_W-1:0] imm;
  logic pcEn, aluZero;

  assign rsIdx = irQ[25:21];
  assign rtIdx = irQ[20:16];
  assign rdIdx = irQ[15:11];
  assign imm   = irQ[IMM_W-1:0];
  assign opField   = irQ[31:26];
  assign funcField = irQ[5:0];

  assign immExt = ctl.extSigned ? {{EXT_PAD{imm[IMM_W-1]}}, imm}
                                : {{EXT_PAD{1'b0}}, imm};
  assign immShifted = immExt << 2;

  assign srcA = ctl.aluSrcA ? aQ : pcQ;
  always_comb begin
    case (ctl.aluSrcB)
      SRCB_FOUR:  srcB = W'(4);
      SRCB_REG:   srcB = bQ;
      SRCB_IMMSH: srcB = immShifted;
      default:    srcB = immExt;
    endcase
  end

  mcdpAlu #(.W(W)) uAlu (
    .opA(srcA), .opB(srcB), .op(ctl.aluOp), .result(aluRes), .zero(aluZero)
  );
  assign zero = aluZero;

  assign wrAddr = ctl.dstSel ? rdIdx : rtIdx;
  assign wrData = ctl.wbSel ? mdrQ : aluOutQ;

  mcdpRegFile #(.W(W), .COUNT(REG_COUNT)) uRegs (
    .clk(clk), .rst(rst),
    .rdAddrA(rsIdx), .rdAddrB(rtIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(ctl.regWr), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign pcEn   = ctl.pcWr | (ctl.pcWrCond & aluZero);
  assign pcNext = ctl.pcSrc ? targetQ : aluRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= '0;
      irQ     <= '0;
      targetQ <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
      mdrQ    <= '0;
    end else begin
      if (pcEn)      pcQ     <= pcNext;
      if (ctl.irWr)  irQ     <= memRData;
      if (ctl.brWr)  targetQ <= aluRes;
      aQ      <= rdDataA;
      bQ      <= rdDataB;
      aluOutQ <= aluRes;
      mdrQ    <= memRData;
    end
  end

  assign memAddr  = ctl.addrSel ? aluOutQ : pcQ;
  assign memWData = bQ;
  assign memWEn   = ctl.memWr;

  // R6: the PC moves only under an enabled write
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pcWr && !(ctl.pcWrCond && zero)) |=> $stable(pcQ));
  // R6: a taken conditional write loads the branch target
  a_r6_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pcWr && ctl.pcWrCond && ctl.pcSrc && zero) |=> (pcQ == $past(targetQ)));
  // R2: a fetch step steps the PC by one word
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcWr && !ctl.pcSrc && !ctl.aluSrcA && ctl.aluSrcB == SRCB_FOUR && ctl.aluOp == ALU_ADD)
    |=> (pcQ == $past(pcQ) + W'(4)));
  // R11: instruction held while its load is off
  a_r11_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.irWr |=> $stable(irQ));
  // R10: equal operands under subtract raise zero
  a_r10_sub_equal: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluOp == ALU_SUB && srcA == srcB) |-> zero);
endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcdpPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pcWr,
  input  logic        pcWrCond,
  input  logic        pcSrc,
  input  logic        irWr,
  input  logic        brWr,
  input  logic        extSigned,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic [2:0]  aluOp,
  input  logic        addrSel,
  input  logic        memWr,
  input  logic        regWr,
  input  logic        dstSel,
  input  logic        wbSel,
  input  logic [31:0] memRData,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  output logic        memWEn,
  output logic [5:0]  opField,
  output logic [5:0]  funcField,
  output logic        zero
);
  dpStrobes_t strobes;

  always_comb begin
    strobes.pcWr      = pcWr;
    strobes.pcWrCond  = pcWrCond;
    strobes.pcSrc     = pcSrc;
    strobes.irWr      = irWr;
    strobes.brWr      = brWr;
    strobes.extSigned = extSigned;
    strobes.aluSrcA   = aluSrcA;
    strobes.aluSrcB   = srcB_e'(aluSrcB);
    strobes.aluOp     = aluOp_e'(aluOp);
    strobes.addrSel   = addrSel;
    strobes.memWr     = memWr;
    strobes.regWr     = regWr;
    strobes.dstSel    = dstSel;
    strobes.wbSel     = wbSel;
  end

  mcdpCore #(.W(WORD_W)) uCore (
    .clk(clk), .rst(rst), .ctl(strobes), .memRData(memRData),
    .memAddr(memAddr), .memWData(memWData), .memWEn(memWEn),
    .opField(opField), .funcField(funcField), .zero(zero)
  );
endmodule

// File: tb/mcDatapath_test.sv
module mcDatapath_test;
  import mcdpPkg::*;

  localparam int MEM_WORDS = 128;
  localparam int MEM_AW    = $clog2(MEM_WORDS);
  localparam logic [5:0] OP_RTYPE = 6'h00, OP_ORI = 6'h0D, OP_LW = 6'h23,
                         OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24,
                         F_OR = 6'h25, F_XOR = 6'h26, F_SLT = 6'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  dpStrobes_t s = '0;
  logic [31:0] memRData, memAddr, memWData;
  logic memWEn, zero;
  logic [5:0] opField, funcField;

  logic [31:0] mem    [MEM_WORDS];
  logic [31:0] refMem [MEM_WORDS];
  logic [31:0] refRegs[32];
  logic [31:0] refPc;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  assign memRData = mem[memAddr[MEM_AW+1:2]];
  always @(posedge clk) if (memWEn) mem[memAddr[MEM_AW+1:2]] <= memWData;

  mcDatapath uut (
    .clk(clk), .rst(rst),
    .pcWr(s.pcWr), .pcWrCond(s.pcWrCond), .pcSrc(s.pcSrc), .irWr(s.irWr),
    .brWr(s.brWr), .extSigned(s.extSigned), .aluSrcA(s.aluSrcA),
    .aluSrcB(s.aluSrcB), .aluOp(s.aluOp), .addrSel(s.addrSel),
    .memWr(s.memWr), .regWr(s.regWr), .dstSel(s.dstSel), .wbSel(s.wbSel),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .memWEn(memWEn), .opField(opField), .funcField(funcField), .zero(zero)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {OP_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic aluOp_e funcToOp(input logic [5:0] fn);
    case (fn)
      F_SUB:   return ALU_SUB;
      F_AND:   return ALU_AND;
      F_OR:    return ALU_OR;
      F_XOR:   return ALU_XOR;
      F_SLT:   return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic [31:0] refAlu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      F_SUB:   return a - b;
      F_AND:   return a & b;
      F_OR:    return a | b;
      F_XOR:   return a ^ b;
      F_SLT:   return (int'(a) < int'(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic putWord(input int idx, input logic [31:0] w);
    mem[idx] = w;
    refMem[idx] = w;
  endtask

  task automatic runInstr();
    logic [31:0] ins, sx, zx, ea;
    logic [5:0] op, fn;
    int rs, rt, rd;
    dpStrobes_t t;
    ins = refMem[refPc[MEM_AW+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'd0, ins[15:0]};
    ea = refRegs[rs] + sx;
    // fetch
    t = '0; t.pcWr = 1; t.irWr = 1; t.aluSrcB = SRCB_FOUR; t.aluOp = ALU_ADD;
    s = t; #1;
    checkEq("R2/R3 fetch address is PC", memAddr, refPc);
    tick();
    refPc = refPc + 32'd4;
    // decode and target
    t = '0; t.brWr = 1; t.extSigned = 1; t.aluSrcB = SRCB_IMMSH; t.aluOp = ALU_ADD;
    s = t; #1;
    checkEq("R2 opcode field", {26'd0, opField}, {26'd0, op});
    checkEq("R2 function field", {26'd0, funcField}, {26'd0, fn});
    tick();
    case (op)
      OP_RTYPE: begin
        t = '0; t.aluSrcA = 1; t.aluSrcB = SRCB_REG; t.aluOp = funcToOp(fn);
        s = t; tick();
        t = '0; t.regWr = 1; t.dstSel = 1;
        s = t; tick();
        if (rd != 0) refRegs[rd] = refAlu(fn, refRegs[rs], refRegs[rt]);
      end
      OP_ORI: begin
        t = '0; t.aluSrcA = 1; t.aluSrcB = SRCB_IMM; t.aluOp = ALU_OR;
        s = t; tick();
        t = '0; t.regWr = 1;
        s = t; tick();
        if (rt != 0) refRegs[rt] = refRegs[rs] | zx;
      end
      OP_LW, OP_SW: begin
        t = '0; t.aluSrcA = 1; t.aluSrcB = SRCB_IMM; t.extSigned = 1; t.aluOp = ALU_ADD;
        s = t; tick();
        t.addrSel = 1; t.memWr = (op == OP_SW);
        s = t; #1;
        checkEq("R3 data address from ALU output register", memAddr, ea);
        checkEq("R11 opcode held during data access", {26'd0, opField}, {26'd0, op});
        if (op == OP_SW) begin
          checkEq("R9 store data from operand B", memWData, refRegs[rt]);
          checkEq("R9 write enable follows request", {31'd0, memWEn}, 32'd1);
        end
        tick();
        if (op == OP_SW) begin
          refMem[ea[MEM_AW+1:2]] = refRegs[rt];
        end else begin
          t = '0; t.regWr = 1; t.wbSel = 1;
          s = t; tick();
          if (rt != 0) refRegs[rt] = refMem[ea[MEM_AW+1:2]];
        end
      end
      default: begin
        t = '0; t.aluSrcA = 1; t.aluSrcB = SRCB_REG; t.aluOp = ALU_SUB;
        t.pcWrCond = 1; t.pcSrc = 1;
        s = t; #1;
        checkEq("R10 zero flag on compare", {31'd0, zero},
                {31'd0, refRegs[rs] == refRegs[rt]});
        tick();
        if (refRegs[rs] == refRegs[rt]) refPc = refPc + (sx << 2);
      end
    endcase
    s = '0;
  endtask

  function automatic int dumpIdx(input int r);
    return (32'h180 >> 2) + r;
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) putWord(i, 32'd0);
    putWord(0,  encI(OP_ORI, 0, 1, 16'h1234));
    putWord(1,  encI(OP_ORI, 0, 2, 16'h00F0));
    putWord(2,  encI(OP_ORI, 0, 0, 16'h5555));
    putWord(3,  encR(1, 2, 3, F_ADD));
    putWord(4,  encR(2, 1, 4, F_SUB));
    putWord(5,  encR(4, 1, 5, F_SLT));
    putWord(6,  encR(1, 2, 6, F_AND));
    putWord(7,  encR(1, 2, 7, F_XOR));
    putWord(8,  encR(1, 2, 8, F_OR));
    putWord(9,  encI(OP_SW, 0, 3, 16'h0100));
    putWord(10, encI(OP_LW, 0, 9, 16'h0100));
    putWord(11, encI(OP_BEQ, 9, 3, 16'h0002));
    putWord(12, encI(OP_ORI, 0, 10, 16'hDEAD));
    putWord(13, encI(OP_ORI, 0, 10, 16'hDEAD));
    putWord(14, encI(OP_BEQ, 1, 2, 16'h0005));
    putWord(15, encI(OP_ORI, 0, 12, 16'h0110));
    putWord(16, encI(OP_SW, 12, 4, 16'hFFFC));
    putWord(17, encI(OP_LW, 12, 11, 16'hFFFC));
    putWord(18, encI(OP_ORI, 0, 13, 16'h8000));
    for (int i = 0; i < 14; i++) putWord(19 + i, encI(OP_SW, 0, i, 16'(32'h180 + 4 * i)));
    putWord(33, encI(OP_BEQ, 0, 0, 16'hFFFF));
    for (int i = 0; i < 32; i++) refRegs[i] = 32'd0;
    refPc = 32'd0;

    s = '0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkEq("R1 PC cleared by reset", memAddr, 32'd0);
    @(negedge clk);

    for (int n = 0; n < 35; n++) runInstr();

    checkEq("R6 self branch keeps PC", refPc, 32'd132);
    checkEq("R8 register 0 unchanged by write", mem[dumpIdx(0)], 32'd0);
    checkEq("R4 add result", mem[dumpIdx(3)], 32'h0000_1324);
    checkEq("R4 subtract result", mem[dumpIdx(4)], 32'hFFFF_EEBC);
    checkEq("R4 signed less-than", mem[dumpIdx(5)], 32'd1);
    checkEq("R4 and result", mem[dumpIdx(6)], 32'h0000_0030);
    checkEq("R4 xor result", mem[dumpIdx(7)], 32'h0000_12C4);
    checkEq("R4 or result", mem[dumpIdx(8)], 32'h0000_12F4);
    checkEq("R7 R12 load write-back via memory-data register", mem[dumpIdx(9)], 32'h0000_1324);
    checkEq("R6 skipped path left register", mem[dumpIdx(10)], 32'd0);
    checkEq("R5 negative offset load", mem[dumpIdx(11)], 32'hFFFF_EEBC);
    checkEq("R5 zero extension of immediate", mem[dumpIdx(13)], 32'h0000_8000);
    checkEq("R9 stored word at negative offset", mem[32'h10C >> 2], 32'hFFFF_EEBC);
    for (int i = 0; i < MEM_WORDS; i++) checkEq("R7 memory image vs reference", mem[i], refMem[i]);

    rst = 1'b1;
    tick();
    rst = 1'b0;
    #1;
    checkEq("R1 mid-run reset clears PC", memAddr, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule